// File: doc/BRIEF.md
# Three-Operand Integer Add Unit

This execution unit adds three 32-bit integers in one pass. Its control comes from a 64-bit instruction word, and the three operand values are supplied on separate inputs. The instruction word carries three kinds of control. Each operand has its own height field, which passes the full word, keeps the low half-word, or keeps the high half-word. Each operand also has a negate bit. A mode field can shift the partial sum of the first two operands left or right by 16 bits before the third operand is added.

An input flag tells the unit whether the instruction is the register form. Only the register form uses the height and mode fields. The constant and immediate forms always produce a plain three-way sum and apply only the negate bits. A height or mode field set to 3 is a reserved encoding. In the register form such a field raises an error flag.

The datapath is combinational. A parameter can place an output register after it, and this register is present by default.

Top module: `tri_add_unit`

## Requirements
- R1: In the register form, with all heights 0, mode 0 and no negation, `sum_out` equals `src_a + src_b + src_c` modulo 2^32.
- R2: Height value 1 keeps only bits 15:0 of its operand, zero-extended. The height field for A sits at instruction bits 36:35, for B at 34:33 and for C at 32:31.
- R3: Height value 2 replaces its operand with the operand logically shifted right by 16, so the upper half-word moves into bits 15:0.
- R4: The negate bit for A is bit 51, for B bit 50 and for C bit 49. A set bit replaces the operand with its two's-complement negation, and this negation is applied after the height selection.
- R5: Mode field bits 38:37 set to 1, in the register form, give `((A + B) >> 16) + C`. The A + B sum is 33 bits wide and the shift is logical, so the carry out of A + B enters result bit 16.
- R6: Mode value 2, in the register form, gives `((A + B) << 16) + C`, and bits shifted above bit 31 are dropped.
- R7: When `reg_form` is 0, the height and mode fields have no effect. The result is the sum of the three operands after negation, and `bad_enc` stays 0.
- R8: In the register form, a height or mode field equal to 3 sets `bad_enc`. A reserved height acts as height 0, and a reserved mode acts as mode 0.
- R9: With the output register present, `sum_out` and `bad_enc` show the result for the inputs of the previous clock edge. Reset clears both outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_word | input | 64 | Instruction word carrying the height, mode and negate fields |
| reg_form | input | 1 | 1 for the register form, 0 for the constant or immediate form |
| src_a | input | 32 | First operand |
| src_b | input | 32 | Second operand |
| src_c | input | 32 | Third operand |
| sum_out | output | 32 | Result |
| bad_enc | output | 1 | Reserved height or mode value seen in the register form |

## Verification
Several properties are checked on every cycle. The error flag must stay low for the non-register form and must rise for a reserved mode. The low-half height selection must clear the upper bits of the selected operand. In left-shift mode, the low 16 result bits must equal the conditioned third operand. The output register must follow the combinational result with one cycle of delay. Only the bench scenarios can show the full arithmetic: carry entry in right-shift mode, wrap and discard in left-shift mode, the order of height and negation, and the fallback behaviour of reserved fields. These are compared against an independent reference model over directed corners and random field combinations.

// File: rtl/tri_add_pkg.sv
package tri_add_pkg;
  localparam int WORD_W  = 32;
  localparam int INSTR_W = 64;
  localparam int NUM_SRC = 3;

  // Field positions within the instruction word; index 0 = A, 1 = B, 2 = C
  localparam int HT_A_LSB  = 35;
  localparam int HT_B_LSB  = 33;
  localparam int HT_C_LSB  = 31;
  localparam int MODE_LSB  = 37;
  localparam int NEG_A_BIT = 51;
  localparam int NEG_B_BIT = 50;
  localparam int NEG_C_BIT = 49;

  typedef enum logic [1:0] {
    HT_FULL = 2'd0,
    HT_LOW  = 2'd1,
    HT_HIGH = 2'd2,
    HT_RSVD = 2'd3
  } height_e;

  typedef enum logic [1:0] {
    MD_SUM  = 2'd0,
    MD_SHR  = 2'd1,
    MD_SHL  = 2'd2,
    MD_RSVD = 2'd3
  } mode_e;

  typedef struct packed {
    logic [NUM_SRC-1:0][1:0] ht;
    logic [NUM_SRC-1:0]      neg;
    mode_e                   mode;
  } ctrl_t;
endpackage

// File: rtl/tri_add_decode.sv
module tri_add_decode
  import tri_add_pkg::*;
#(
  parameter int IW = INSTR_W
) (
  input  logic [IW-1:0] instr_word,
  input  logic          reg_form,
  output ctrl_t         ctrl,
  output logic          rsvd_hit
);
  logic [NUM_SRC-1:0][1:0] raw_ht;
  logic [1:0]              raw_mode;
  logic [NUM_SRC-1:0]      ht_rsvd;

  assign raw_ht[0] = instr_word[HT_A_LSB +: 2];
  assign raw_ht[1] = instr_word[HT_B_LSB +: 2];
  assign raw_ht[2] = instr_word[HT_C_LSB +: 2];
  assign raw_mode  = instr_word[MODE_LSB +: 2];

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_ht
    assign ht_rsvd[i] = (raw_ht[i] == HT_RSVD);
    // Non-register forms and reserved values fall back to the full operand
    assign ctrl.ht[i] = (reg_form && !ht_rsvd[i]) ? raw_ht[i] : HT_FULL;
  end

  assign ctrl.neg[0] = instr_word[NEG_A_BIT];
  assign ctrl.neg[1] = instr_word[NEG_B_BIT];
  assign ctrl.neg[2] = instr_word[NEG_C_BIT];

  always_comb begin
    if (reg_form && raw_mode != MD_RSVD) ctrl.mode = mode_e'(raw_mode);
    else                                 ctrl.mode = MD_SUM;
  end

  assign rsvd_hit = reg_form && ((|ht_rsvd) || (raw_mode == MD_RSVD));
endmodule

// File: rtl/tri_add_operand.sv
module tri_add_operand
  import tri_add_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic [W-1:0] src,
  input  logic [1:0]   ht,
  input  logic         neg,
  output logic [W-1:0] sel,
  output logic [W-1:0] cond
);
  localparam int HALF = W / 2;

  function automatic logic [W-1:0] pick_height(input logic [W-1:0] v, input logic [1:0] h);
    case (h)
      HT_LOW:  pick_height = {{(W-HALF){1'b0}}, v[HALF-1:0]};
      HT_HIGH: pick_height = v >> HALF;
      default: pick_height = v;
    endcase
  endfunction

  function automatic logic [W-1:0] twos_neg(input logic [W-1:0] v, input logic en);
    twos_neg = en ? (~v + W'(1)) : v;
  endfunction

  assign sel  = pick_height(src, ht);
  assign cond = twos_neg(sel, neg);
endmodule

// File: rtl/tri_add_combine.sv
module tri_add_combine
  import tri_add_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  input  mode_e        mode,
  output logic [W-1:0] res
);
  localparam int HALF = W / 2;

  logic [W:0] part;

  function automatic logic [W-1:0] fold(input logic [W:0] p, input logic [W-1:0] z, input mode_e m);
    logic [W:0] shr;
    case (m)
      MD_SHR: begin
        shr  = p >> HALF;
        fold = shr[W-1:0] + z;
      end
      MD_SHL:  fold = (p[W-1:0] << HALF) + z;
      default: fold = p[W-1:0] + z;
    endcase
  endfunction

  assign part = {1'b0, a} + {1'b0, b};
  assign res  = fold(part, c, mode);
endmodule

// File: rtl/tri_add_unit.sv
module tri_add_unit
  import tri_add_pkg::*;
#(
  parameter int DATA_W  = WORD_W,
  parameter int IW      = INSTR_W,
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IW-1:0]     instr_word,
  input  logic              reg_form,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [DATA_W-1:0] src_c,
  output logic [DATA_W-1:0] sum_out,
  output logic              bad_enc
);
  ctrl_t                          ctrl;
  logic                           comb_err;
  logic [DATA_W-1:0]              comb_result;
  logic [NUM_SRC-1:0][DATA_W-1:0] srcs;
  logic [NUM_SRC-1:0][DATA_W-1:0] sels;
  logic [NUM_SRC-1:0][DATA_W-1:0] conds;
  logic [DATA_W-1:0]              sel_a;
  logic [DATA_W-1:0]              cond_c;

  assign srcs[0] = src_a;
  assign srcs[1] = src_b;
  assign srcs[2] = src_c;

  tri_add_decode #(.IW(IW)) u_dec (
    .instr_word (instr_word),
    .reg_form   (reg_form),
    .ctrl       (ctrl),
    .rsvd_hit   (comb_err)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_opnd
    tri_add_operand #(.W(DATA_W)) u_opnd (
      .src  (srcs[i]),
      .ht   (ctrl.ht[i]),
      .neg  (ctrl.neg[i]),
      .sel  (sels[i]),
      .cond (conds[i])
    );
  end

  assign sel_a  = sels[0];
  assign cond_c = conds[2];

  tri_add_combine #(.W(DATA_W)) u_comb (
    .a    (conds[0]),
    .b    (conds[1]),
    .c    (conds[2]),
    .mode (ctrl.mode),
    .res  (comb_result)
  );

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sum_out <= '0;
        bad_enc <= 1'b0;
      end else begin
        sum_out <= comb_result;
        bad_enc <= comb_err;
      end
    end
  end else begin : g_wire
    assign sum_out = comb_result;
    assign bad_enc = comb_err;
  end
endmodule

// File: rtl/tri_add_checker.sv
module tri_add_checker #(
  parameter int W       = 32,
  parameter int IW      = 64,
  parameter bit OUT_REG = 1'b1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [IW-1:0] instr_word,
  input logic          reg_form,
  input logic [W-1:0]  comb_result,
  input logic          comb_err,
  input logic [W-1:0]  sel_a,
  input logic [W-1:0]  cond_c,
  input logic [W-1:0]  sum_out,
  input logic          bad_enc
);
  logic live;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;
  end

  AST_CONST_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_form |-> !comb_err); // R7

  AST_MODE_RSVD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_form && instr_word[38:37] == 2'd3) |-> comb_err); // R8

  AST_LOW_HALF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_form && instr_word[36:35] == 2'd1) |-> (sel_a[W-1:W/2] == '0)); // R2

  AST_SHL_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_form && instr_word[38:37] == 2'd2) |-> (comb_result[W/2-1:0] == cond_c[W/2-1:0])); // R6

  if (OUT_REG) begin : g_reg_chk
    AST_REG_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      live |-> (sum_out == $past(comb_result) && bad_enc == $past(comb_err))); // R9
  end
endmodule

bind tri_add_unit tri_add_checker #(.W(DATA_W), .IW(IW), .OUT_REG(OUT_REG)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .instr_word  (instr_word),
  .reg_form    (reg_form),
  .comb_result (comb_result),
  .comb_err    (comb_err),
  .sel_a       (sel_a),
  .cond_c      (cond_c),
  .sum_out     (sum_out),
  .bad_enc     (bad_enc)
);

// File: tb/sim_tri_add_unit.sv
module sim_tri_add_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] instr_word = '0;
  logic        reg_form = 1'b0;
  logic [31:0] src_a = '0, src_b = '0, src_c = '0;
  logic [31:0] sum_out;
  logic        bad_enc;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tri_add_unit u0 (
    .clk(clk), .rst_n(rst_n), .instr_word(instr_word), .reg_form(reg_form),
    .src_a(src_a), .src_b(src_b), .src_c(src_c), .sum_out(sum_out), .bad_enc(bad_enc)
  );

  function automatic longint unsigned shape(input longint unsigned v, input int h,
                                            input bit n, input bit rf);
    longint unsigned x = v;
    if (rf && h == 1) x = v % 65536;
    else if (rf && h == 2) x = v / 65536;
    if (n) x = (64'h1_0000_0000 - x) % 64'h1_0000_0000;
    return x;
  endfunction

  function automatic logic [31:0] ref_sum(input logic [63:0] iw, input bit rf,
                                          input logic [31:0] a, input logic [31:0] b,
                                          input logic [31:0] c);
    longint unsigned x, y, z, s, r;
    int md = int'(iw[38:37]);
    x = shape(a, int'(iw[36:35]), iw[51], rf);
    y = shape(b, int'(iw[34:33]), iw[50], rf);
    z = shape(c, int'(iw[32:31]), iw[49], rf);
    s = x + y;
    if (rf && md == 1)      r = s / 65536 + z;
    else if (rf && md == 2) r = s * 65536 + z;
    else                    r = s + z;
    return r[31:0];
  endfunction

  function automatic bit ref_err(input logic [63:0] iw, input bit rf);
    return rf && (iw[38:37] == 2'd3 || iw[36:35] == 2'd3 ||
                  iw[34:33] == 2'd3 || iw[32:31] == 2'd3);
  endfunction

  function automatic logic [63:0] mk(input int ha, input int hb, input int hc, input int md,
                                     input bit na, input bit nb, input bit nc);
    logic [63:0] w = '0;
    w[36:35] = 2'(ha); w[34:33] = 2'(hb); w[32:31] = 2'(hc);
    w[38:37] = 2'(md); w[51] = na; w[50] = nb; w[49] = nc;
    return w;
  endfunction

  task automatic check(input string req, input logic [31:0] got_s, input logic [31:0] exp_s,
                       input bit got_e, input bit exp_e);
    n_checks++;
    if (got_s !== exp_s || got_e !== exp_e) begin
      n_fail++;
      $display("FAIL %s: sum_out=%h err=%b expected sum_out=%h err=%b", req, got_s, got_e, exp_s, exp_e);
    end
  endtask

  // Drive at a falling edge, result registered at the next rising edge, sample at the following falling edge
  task automatic run(input string req, input logic [63:0] iw, input bit rf,
                     input logic [31:0] a, input logic [31:0] b, input logic [31:0] c);
    @(negedge clk);
    instr_word = iw; reg_form = rf; src_a = a; src_b = b; src_c = c;
    @(negedge clk);
    check(req, sum_out, ref_sum(iw, rf, a, b, c), bad_enc, ref_err(iw, rf));
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed_val;
    seed_val = $urandom(32'd5021);
    instr_word = 64'hFFFF_FFFF_FFFF_FFFF; reg_form = 1'b1;
    src_a = 32'h1234_5678; src_b = 32'h1; src_c = 32'h2;
    repeat (3) @(negedge clk);
    check("R9 reset", sum_out, 32'h0, bad_enc, 1'b0);
    rst_n = 1'b1;

    run("R1 plain",         mk(0,0,0,0,0,0,0), 1, 32'h1000_0001, 32'h2000_0002, 32'h3000_0003);
    run("R1 wrap",          mk(0,0,0,0,0,0,0), 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0003);
    run("R2 low halves",    mk(1,1,1,0,0,0,0), 1, 32'hABCD_0011, 32'h1234_0022, 32'h5555_0033);
    run("R3 high halves",   mk(2,2,2,0,0,0,0), 1, 32'h0011_FFFF, 32'h0022_FFFF, 32'h0033_FFFF);
    run("R4 negate A",      mk(0,0,0,0,1,0,0), 1, 32'h0000_0005, 32'h0000_0010, 32'h0);
    run("R4 height then neg", mk(2,0,0,0,1,0,0), 1, 32'h0003_0000, 32'h0, 32'h0);
    run("R4 negate B C",    mk(0,0,0,0,0,1,1), 1, 32'h100, 32'h1, 32'h2);
    run("R5 carry enters",  mk(0,0,0,1,0,0,0), 1, 32'h8000_0000, 32'h8000_0000, 32'h1);
    run("R5 shr basic",     mk(0,0,0,1,0,0,0), 1, 32'h1234_0000, 32'h0001_FFFF, 32'h10);
    run("R6 shl discard",   mk(0,0,0,2,0,0,0), 1, 32'hFFFF_0001, 32'h0001_0002, 32'h0000_00AB);
    run("R7 const ignores", mk(1,2,1,2,0,0,0), 0, 32'hDEAD_BEEF, 32'h0BAD_F00D, 32'h1111_1111);
    run("R7 const neg",     mk(3,3,3,3,1,0,1), 0, 32'h50, 32'h100, 32'h20);
    run("R8 rsvd height",   mk(3,0,0,0,0,0,0), 1, 32'hABCD_1234, 32'h1, 32'h1);
    run("R8 rsvd mode",     mk(0,0,0,3,0,0,0), 1, 32'h8000_0000, 32'h8000_0000, 32'h7);
    run("R8 rsvd C height", mk(0,0,3,1,0,0,0), 1, 32'h0001_0000, 32'h0001_0000, 32'hFFFF_0000);

    for (int i = 0; i < 600; i++) begin
      logic [63:0] iw;
      iw = {$urandom, $urandom};
      run("R1 R5 R6 R7 R8 random", iw, 1'($urandom), $urandom, $urandom, $urandom);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule